// File: doc/BRIEF.md
# Paged Switch Register Access Sequencer

This block lets on-chip logic read and write the 32-bit registers of an Ethernet switch core. The switch core only exposes a 16-bit management bus. A requester hands over one operation at a time: a word address, write data, a mask and a timeout. The block then drives the management bus command port with the half-word transactions the operation needs, and answers with a single-cycle acknowledge that carries the result and an error flag.

The switch register space is banked. The upper address bits pick a bank ("page"), which is selected by writing a dedicated management register. The block remembers the page it last selected. It writes the page register only when a request targets a different page, and it then waits a fixed settling time before any data access. A 32-bit value is split into two half-word accesses on consecutive register numbers. The order of the two writes can be chosen at run time. Besides plain reads and writes, the block offers read-modify-write, masked polling with a retry limit, and single half-word accesses.

The bus frame engine sits behind the command port: `mdio_start` launches one transaction and `mdio_done` ends it. The requester keeps `req_valid` and the request fields stable until it sees `req_ack`, and drops `req_valid` in the acknowledge cycle.

Top module: `mdio_page_seq`

## Requirements
- R1: The address splits into page = addr[17:9], selector = addr[8:6] and register = addr[5:1]. Every data access goes to bus PHY address 0x10 OR selector, at the register number (or register+1, modulo 32).
- R2: A page-select transaction is a write of the 9-bit page, zero-extended, to PHY 0x18 register 0. It is issued only when the request's page differs from the stored page. After reset no page is stored, so the first request always issues one.
- R3: After a page-select transaction completes, no data transaction starts for at least SETTLE_CYC = max(1, CLK_KHZ*SETTLE_US/1000) clock cycles.
- R4: Operation code 0 (read) reads register r, then register r+1, and returns {second, first} on rsp_data.
- R5: Operation code 1 (write) sends wdata[15:0] to r and wdata[31:16] to r+1. With cfg_lo_first=1 the r write goes first; with cfg_lo_first=0 the r+1 write goes first.
- R6: Operation code 2 (read-modify-write) reads like R4. It then writes (old & ~req_mask) | req_wdata in the R5 order and returns the old value.
- R7: Operation code 3 (poll) repeats the R4 read until (value & req_mask) == req_wdata. It then acknowledges with rsp_err=0 and the matching value. Between two attempts at least GAP_CYC = max(1, CLK_KHZ*GAP_US/1000) cycles elapse.
- R8: A poll whose first req_timeout+1 attempts all mismatch stops after exactly that many attempts and acknowledges with rsp_err=1.
- R9: Half-word operations issue one transaction. Code 4 reads r and returns {16'h0, data}. Code 5 reads at address+2 and returns {data, 16'h0}. Code 6 writes wdata[15:0] to r. Code 7 writes wdata[31:16] at address+2.
- R10: rsp_err is the OR of mdio_err over all transactions of the current request and is cleared when a new request is accepted.
- R11: At most one bus transaction is outstanding: mdio_start lasts one cycle and does not recur until mdio_done has returned. req_ack is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_ack |
| req_op | input | 3 | Operation code (see R4 to R9) |
| req_addr | input | 18 | Switch word address |
| req_wdata | input | 32 | Write data, set bits, or poll expected value |
| req_mask | input | 32 | Clear mask (modify) or compare mask (poll) |
| req_timeout | input | TMO_W | Extra poll attempts allowed |
| cfg_lo_first | input | 1 | Half-word write order select |
| req_ack | output | 1 | One-cycle completion strobe |
| rsp_data | output | 32 | Read result, valid with req_ack |
| rsp_err | output | 1 | Error or poll timeout, valid with req_ack |
| mdio_start | output | 1 | Launch one bus transaction |
| mdio_write | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Bus PHY address |
| mdio_reg | output | 5 | Bus register number |
| mdio_wdata | output | 16 | Bus write data |
| mdio_rdata | input | 16 | Bus read data, valid with mdio_done |
| mdio_done | input | 1 | Transaction finished |
| mdio_err | input | 1 | Transaction failed, valid with mdio_done |

## Verification
The hardest situation to reach is a poll whose target changes between attempts. The bench's bus responder counts reads of one chosen register and swaps in a matching value only from a preset attempt number onward. One poll therefore sees two misses, then a hit, with the retry gap measured between attempts. A second poll never matches and runs through exactly its timeout count. The page cache is driven through the sequence page 0, 3, 3, 5, 3, which proves that page writes are skipped on a repeat and reissued on a return.

// File: rtl/mdio_page_seq_pkg.sv
package mdio_page_seq_pkg;
   localparam int ADDR_W   = 18;
   localparam int HALF_W   = 16;
   localparam int DATA_W   = 2 * HALF_W;
   localparam int PAGE_W   = 9;
   localparam int PAGE_LSB = 9;
   localparam int SEL_W    = 3;
   localparam int SEL_LSB  = 6;
   localparam int REG_W    = 5;
   localparam int REG_LSB  = 1;
   localparam logic [4:0] PAGE_PHY  = 5'h18;
   localparam logic [4:0] DATA_PHY  = 5'h10;

   typedef enum logic [2:0] {
      OP_RD32 = 3'd0, OP_WR32 = 3'd1, OP_RMW  = 3'd2, OP_POLL = 3'd3,
      OP_RDLO = 3'd4, OP_RDHI = 3'd5, OP_WRLO = 3'd6, OP_WRHI = 3'd7
   } op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_PG, S_SETTLE, S_RD1, S_RD2, S_WR1, S_WR2, S_GAP, S_RESP
   } st_e;
endpackage

// File: rtl/mdio_page_addr_split.sv
module mdio_page_addr_split
   import mdio_page_seq_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output logic [PAGE_W-1:0] page,
   output logic [SEL_W-1:0]  sel,
   output logic [REG_W-1:0]  rg,
   output logic [REG_W-1:0]  rg_nx
);
   assign page  = addr[PAGE_LSB +: PAGE_W];
   assign sel   = addr[SEL_LSB +: SEL_W];
   assign rg    = addr[REG_LSB +: REG_W];
   assign rg_nx = rg + REG_W'(1);

   logic unused_lsb;
   assign unused_lsb = addr[0];
endmodule

// File: rtl/mdio_page_timer.sv
module mdio_page_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/mdio_page_txn.sv
module mdio_page_txn
   import mdio_page_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              wr,
   input  logic [4:0]        phy,
   input  logic [4:0]        rg,
   input  logic [HALF_W-1:0] wd,
   input  logic              mdio_done,
   output logic              mdio_start,
   output logic              mdio_write,
   output logic [4:0]        mdio_phy,
   output logic [4:0]        mdio_reg,
   output logic [HALF_W-1:0] mdio_wdata,
   output logic              fin
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         mdio_start <= 1'b0;
         mdio_write <= 1'b0;
         mdio_phy   <= '0;
         mdio_reg   <= '0;
         mdio_wdata <= '0;
      end else begin
         mdio_start <= go;
         if (go) begin
            busy_q     <= 1'b1;
            mdio_write <= wr;
            mdio_phy   <= phy;
            mdio_reg   <= rg;
            mdio_wdata <= wd;
         end else if (fin) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign fin = busy_q && mdio_done && !mdio_start;
endmodule

// File: rtl/mdio_page_seq.sv
module mdio_page_seq
   import mdio_page_seq_pkg::*;
#(
   parameter int CLK_KHZ   = 100000,
   parameter int SETTLE_US = 2000,
   parameter int GAP_US    = 1,
   parameter int TMO_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] req_mask,
   input  logic [TMO_W-1:0]  req_timeout,
   input  logic              cfg_lo_first,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              mdio_start,
   output logic              mdio_write,
   output logic [4:0]        mdio_phy,
   output logic [4:0]        mdio_reg,
   output logic [HALF_W-1:0] mdio_wdata,
   input  logic [HALF_W-1:0] mdio_rdata,
   input  logic              mdio_done,
   input  logic              mdio_err
);
   localparam int SETTLE_RAW = CLK_KHZ * SETTLE_US / 1000;
   localparam int GAP_RAW    = CLK_KHZ * GAP_US / 1000;
   localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
   localparam int GAP_CYC    = (GAP_RAW < 1) ? 1 : GAP_RAW;
   localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("CLK_KHZ must be positive");
      end
      if (SETTLE_US < 1 || GAP_US < 1) begin : g_bad_wait
         $error("wait times must be positive");
      end
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("TMO_W must be 1..32");
      end
   endgenerate

   st_e               st_q;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wval_q, mask_q;
   logic [HALF_W-1:0] lo_q;
   logic [TMO_W-1:0]  tmo_q;
   logic [PAGE_W-1:0] page_q;
   logic              page_vld_q, lof_q, pend_q, err_q, pfail_q;

   // incoming request: effective address and page
   logic              req_hi;
   logic [ADDR_W-1:0] req_eff;
   logic [PAGE_W-1:0] req_page;
   assign req_hi   = (op_e'(req_op) == OP_RDHI) || (op_e'(req_op) == OP_WRHI);
   assign req_eff  = req_addr + (req_hi ? ADDR_W'(2) : ADDR_W'(0));
   assign req_page = req_eff[PAGE_LSB +: PAGE_W];
   logic unused_eff;
   assign unused_eff = ^{req_eff[PAGE_LSB-1:0]};

   logic [PAGE_W-1:0] page;
   logic [SEL_W-1:0]  sel;
   logic [REG_W-1:0]  rg, rg_nx;
   mdio_page_addr_split u_split (
      .addr(addr_q), .page(page), .sel(sel), .rg(rg), .rg_nx(rg_nx));

   // transaction request per state
   logic              t_go, t_wr, t_fin, is_txn;
   logic [4:0]        t_phy, t_reg;
   logic [HALF_W-1:0] t_wd;

   always_comb begin
      t_wr  = 1'b0;
      t_phy = DATA_PHY | {2'b00, sel};
      t_reg = rg;
      t_wd  = '0;
      case (st_q)
         S_PG: begin
            t_wr  = 1'b1;
            t_phy = PAGE_PHY;
            t_reg = '0;
            t_wd  = HALF_W'(page);
         end
         S_RD2: t_reg = rg_nx;
         S_WR1: begin
            t_wr  = 1'b1;
            t_reg = lof_q ? rg : rg_nx;
            t_wd  = lof_q ? wval_q[HALF_W-1:0] : wval_q[DATA_W-1:HALF_W];
         end
         S_WR2: begin
            t_wr  = 1'b1;
            t_reg = lof_q ? rg_nx : rg;
            t_wd  = lof_q ? wval_q[DATA_W-1:HALF_W] : wval_q[HALF_W-1:0];
         end
         default: ;
      endcase
   end

   assign is_txn = (st_q == S_PG) || (st_q == S_RD1) || (st_q == S_RD2) ||
                   (st_q == S_WR1) || (st_q == S_WR2);
   assign t_go   = is_txn && !pend_q;

   mdio_page_txn u_txn (
      .clk(clk), .rst_n(rst_n), .go(t_go), .wr(t_wr), .phy(t_phy),
      .rg(t_reg), .wd(t_wd), .mdio_done(mdio_done),
      .mdio_start(mdio_start), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
      .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .fin(t_fin));

   // shared wait timer: page settle and poll retry gap
   logic [DATA_W-1:0] cur;
   logic              hit, tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   assign cur      = {mdio_rdata, lo_q};
   assign hit      = ((cur & mask_q) == wval_q);
   assign tmr_load = t_fin && ((st_q == S_PG) ||
                     (st_q == S_RD2 && op_q == OP_POLL && !hit && tmo_q != '0));
   assign tmr_val  = (st_q == S_PG) ? CNT_W'(SETTLE_CYC) : CNT_W'(GAP_CYC);

   mdio_page_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .zero(tmr_zero));

   function automatic st_e first_step(op_e op);
      case (op)
         OP_WR32, OP_WRLO, OP_WRHI: return S_WR1;
         default:                   return S_RD1;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         op_q       <= OP_RD32;
         addr_q     <= '0;
         wval_q     <= '0;
         mask_q     <= '0;
         lo_q       <= '0;
         tmo_q      <= '0;
         page_q     <= '0;
         page_vld_q <= 1'b0;
         lof_q      <= 1'b0;
         pend_q     <= 1'b0;
         err_q      <= 1'b0;
         pfail_q    <= 1'b0;
         rsp_data   <= '0;
      end else begin
         if (t_go)       pend_q <= 1'b1;
         else if (t_fin) pend_q <= 1'b0;
         if (t_fin && mdio_err) err_q <= 1'b1;

         case (st_q)
            S_IDLE: if (req_valid) begin
               op_q    <= op_e'(req_op);
               addr_q  <= req_eff;
               mask_q  <= req_mask;
               tmo_q   <= req_timeout;
               err_q   <= 1'b0;
               pfail_q <= 1'b0;
               rsp_data <= '0;
               case (op_e'(req_op))
                  OP_WRLO: begin wval_q <= {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};     lof_q <= 1'b1; end
                  OP_WRHI: begin wval_q <= {{HALF_W{1'b0}}, req_wdata[DATA_W-1:HALF_W]}; lof_q <= 1'b1; end
                  default: begin wval_q <= req_wdata; lof_q <= cfg_lo_first; end
               endcase
               st_q <= (page_vld_q && page_q == req_page) ?
                       first_step(op_e'(req_op)) : S_PG;
            end
            S_PG: if (t_fin) begin
               page_q     <= page;
               page_vld_q <= 1'b1;
               st_q       <= S_SETTLE;
            end
            S_SETTLE: if (tmr_zero) st_q <= first_step(op_q);
            S_RD1: if (t_fin) begin
               case (op_q)
                  OP_RDLO: begin rsp_data <= {{HALF_W{1'b0}}, mdio_rdata}; st_q <= S_RESP; end
                  OP_RDHI: begin rsp_data <= {mdio_rdata, {HALF_W{1'b0}}}; st_q <= S_RESP; end
                  default: begin lo_q <= mdio_rdata; st_q <= S_RD2; end
               endcase
            end
            S_RD2: if (t_fin) begin
               rsp_data <= cur;
               case (op_q)
                  OP_RMW: begin
                     wval_q <= (cur & ~mask_q) | wval_q;
                     st_q   <= S_WR1;
                  end
                  OP_POLL: begin
                     if (hit)               st_q <= S_RESP;
                     else if (tmo_q == '0) begin pfail_q <= 1'b1; st_q <= S_RESP; end
                     else                   st_q <= S_GAP;
                  end
                  default: st_q <= S_RESP;
               endcase
            end
            S_GAP: if (tmr_zero) begin
               tmo_q <= tmo_q - TMO_W'(1);
               st_q  <= S_RD1;
            end
            S_WR1: if (t_fin) st_q <= (op_q == OP_WR32 || op_q == OP_RMW) ? S_WR2 : S_RESP;
            S_WR2: if (t_fin) st_q <= S_RESP;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign req_ack = (st_q == S_RESP);
   assign rsp_err = err_q | pfail_q;
endmodule

// File: rtl/mdio_page_seq_chk.sv
module mdio_page_seq_chk #(
   parameter int SETTLE_CYC = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mdio_start,
   input logic       mdio_write,
   input logic [4:0] mdio_phy,
   input logic [4:0] mdio_reg,
   input logic       mdio_done,
   input logic       req_ack
);
   logic        out_q, pg_out_q, recent_q;
   logic [31:0] since_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q    <= 1'b0;
         pg_out_q <= 1'b0;
         recent_q <= 1'b0;
         since_q  <= '0;
      end else begin
         if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 32'd1;
         if (mdio_start) begin
            out_q    <= 1'b1;
            pg_out_q <= (mdio_phy == 5'h18);
            if (mdio_phy != 5'h18) recent_q <= 1'b0;
         end else if (mdio_done) begin
            out_q <= 1'b0;
            if (pg_out_q) begin
               recent_q <= 1'b1;
               since_q  <= '0;
            end
         end
      end
   end

   assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_start |-> !out_q);
   assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   assert_page_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_start && mdio_phy == 5'h18) |-> (mdio_write && mdio_reg == 5'd0));
   assert_data_phy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_start && mdio_phy != 5'h18) |-> (mdio_phy[4:3] == 2'b10));
   assert_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_start && mdio_phy != 5'h18 && recent_q) |-> (since_q >= SETTLE_CYC));
endmodule

bind mdio_page_seq mdio_page_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .mdio_start(mdio_start), .mdio_write(mdio_write),
   .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_done(mdio_done),
   .req_ack(req_ack));

// File: tb/mdio_page_seq_test.sv
module mdio_page_seq_test;
   localparam int CLK_KHZ = 2000;
   localparam int SETTLE  = 4000;
   localparam int GAP     = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, req_valid, cfg_lo_first, req_ack, rsp_err;
   logic [2:0]  req_op;
   logic [17:0] req_addr;
   logic [31:0] req_wdata, req_mask, rsp_data;
   logic [15:0] req_timeout;
   logic        mdio_start, mdio_write, mdio_done, mdio_err;
   logic [4:0]  mdio_phy, mdio_reg;
   logic [15:0] mdio_wdata, mdio_rdata;

   mdio_page_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(2000), .GAP_US(1), .TMO_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .req_timeout(req_timeout), .cfg_lo_first(cfg_lo_first),
      .req_ack(req_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .mdio_start(mdio_start), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
      .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata),
      .mdio_done(mdio_done), .mdio_err(mdio_err));

   // ---------------- bus responder model ----------------
   logic [15:0] mem [0:255];
   logic [4:0]  log_phy [0:255];
   logic [4:0]  log_reg [0:255];
   logic        log_wr  [0:255];
   logic [15:0] log_wd  [0:255];
   int          log_t   [0:255];
   int          log_n, cyc = 0, cnt_m, tgt_reads;
   int          poll_base = 32'h7FFF_FFFF;
   logic [15:0] poll_val = 16'h0, rd_m;
   logic        busy_m, err_inj = 1'b0;

   always @(posedge clk) begin
      cyc       <= cyc + 1;
      mdio_done <= 1'b0;
      mdio_err  <= 1'b0;
      if (!rst_n) begin
         busy_m    <= 1'b0;
         log_n     <= 0;
         tgt_reads <= 0;
         for (int i = 0; i < 256; i++) mem[i] <= 16'h0;
      end else begin
         if (busy_m) begin
            if (cnt_m == 0) begin
               mdio_done  <= 1'b1;
               mdio_rdata <= rd_m;
               mdio_err   <= err_inj;
               busy_m     <= 1'b0;
            end else cnt_m <= cnt_m - 1;
         end
         if (mdio_start) begin
            log_phy[log_n[7:0]] <= mdio_phy;
            log_reg[log_n[7:0]] <= mdio_reg;
            log_wr[log_n[7:0]]  <= mdio_write;
            log_wd[log_n[7:0]]  <= mdio_wdata;
            log_t[log_n[7:0]]   <= cyc;
            log_n  <= log_n + 1;
            busy_m <= 1'b1;
            cnt_m  <= 2;
            if (mdio_write) begin
               if (mdio_phy[4:3] == 2'b10) mem[{mdio_phy[2:0], mdio_reg}] <= mdio_wdata;
            end else if (mdio_phy == 5'h12 && mdio_reg == 5'd8) begin
               tgt_reads <= tgt_reads + 1;
               rd_m <= (tgt_reads + 1 >= poll_base) ? poll_val : mem[{3'd2, 5'd8}];
            end else begin
               rd_m <= mem[{mdio_phy[2:0], mdio_reg}];
            end
         end
      end
   end

   // ---------------- checking helpers ----------------
   int n_checks = 0, n_fail = 0, base, nent;
   logic [31:0] rd_d;
   logic        rd_e;

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic chk_ent(input string rq, input int i, input logic wr,
                          input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
      chk(rq, $sformatf("entry %0d", i),
          {5'b0, log_wr[base+i], log_phy[base+i], log_reg[base+i], log_wd[base+i]},
          {5'b0, wr, phy, rg, wd});
   endtask

   task automatic do_req(input logic [2:0] op, input logic [17:0] a, input logic [31:0] wd,
                         input logic [31:0] m, input logic [15:0] t);
      @(negedge clk);
      base = log_n;
      req_op = op; req_addr = a; req_wdata = wd; req_mask = m; req_timeout = t;
      req_valid = 1'b1;
      do @(negedge clk); while (!req_ack);
      rd_d = rsp_data;
      rd_e = rsp_err;
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11", "ack width", {31'b0, req_ack}, 32'd0);
      nent = log_n - base;
   endtask

   localparam logic [17:0] A_P0   = 18'h00040;                  // page0 sel1 reg0
   localparam logic [17:0] A_P3R4 = (3 << 9) | (2 << 6) | (4 << 1);
   localparam logic [17:0] A_P3R8 = (3 << 9) | (2 << 6) | (8 << 1);
   localparam logic [17:0] A_P5   = (5 << 9) | (1 << 6) | (2 << 1);

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk("R11", "ack after reset", {31'b0, req_ack}, 32'd0);
      chk("R11", "start after reset", {31'b0, mdio_start}, 32'd0);
   endtask

   task automatic t_first_read;     // R2 first access, R3 settle, R4 read
      do_req(3'd0, A_P0, 0, 0, 0);
      chk("R2", "entries", nent, 3);
      chk_ent("R2", 0, 1'b1, 5'h18, 5'd0, 16'h0000);
      chk_ent("R4", 1, 1'b0, 5'h11, 5'd0, 16'h0);
      chk_ent("R4", 2, 1'b0, 5'h11, 5'd1, 16'h0);
      chk("R3", "settle ok", {31'b0, (log_t[base+1] - log_t[base]) >= SETTLE}, 32'd1);
      chk("R4", "data", rd_d, 32'h0);
      chk("R10", "err", {31'b0, rd_e}, 32'd0);
   endtask

   task automatic t_write_lofirst;  // R5 lo first, R1 fields, R2 page change
      cfg_lo_first = 1'b1;
      do_req(3'd1, A_P3R4, 32'hDEADBEEF, 0, 0);
      chk("R2", "entries", nent, 3);
      chk_ent("R2", 0, 1'b1, 5'h18, 5'd0, 16'h0003);
      chk_ent("R5", 1, 1'b1, 5'h12, 5'd4, 16'hBEEF);
      chk_ent("R5", 2, 1'b1, 5'h12, 5'd5, 16'hDEAD);
      chk("R3", "settle ok", {31'b0, (log_t[base+1] - log_t[base]) >= SETTLE}, 32'd1);
   endtask

   task automatic t_read_same_page; // R2 no repeat page write, R4
      do_req(3'd0, A_P3R4, 0, 0, 0);
      chk("R2", "no page write", nent, 2);
      chk_ent("R4", 0, 1'b0, 5'h12, 5'd4, 16'h0);
      chk_ent("R4", 1, 1'b0, 5'h12, 5'd5, 16'h0);
      chk("R4", "data", rd_d, 32'hDEADBEEF);
   endtask

   task automatic t_write_hifirst;  // R5 hi first
      cfg_lo_first = 1'b0;
      do_req(3'd1, A_P3R8, 32'h12345678, 0, 0);
      chk("R5", "entries", nent, 2);
      chk_ent("R5", 0, 1'b1, 5'h12, 5'd9, 16'h1234);
      chk_ent("R5", 1, 1'b1, 5'h12, 5'd8, 16'h5678);
      do_req(3'd0, A_P3R8, 0, 0, 0);
      chk("R5", "readback", rd_d, 32'h12345678);
   endtask

   task automatic t_rmw;            // R6
      cfg_lo_first = 1'b0;
      do_req(3'd2, A_P3R4, 32'h00005500, 32'h0000FF00, 0);
      chk("R6", "entries", nent, 4);
      chk_ent("R6", 0, 1'b0, 5'h12, 5'd4, 16'h0);
      chk_ent("R6", 1, 1'b0, 5'h12, 5'd5, 16'h0);
      chk_ent("R6", 2, 1'b1, 5'h12, 5'd5, 16'hDEAD);
      chk_ent("R6", 3, 1'b1, 5'h12, 5'd4, 16'h55EF);
      chk("R6", "old value", rd_d, 32'hDEADBEEF);
      do_req(3'd0, A_P3R4, 0, 0, 0);
      chk("R6", "readback", rd_d, 32'hDEAD55EF);
   endtask

   task automatic t_page_switch;    // R1, R2 reissue on return
      do_req(3'd0, A_P5, 0, 0, 0);
      chk("R2", "entries p5", nent, 3);
      chk_ent("R2", 0, 1'b1, 5'h18, 5'd0, 16'h0005);
      chk_ent("R1", 1, 1'b0, 5'h11, 5'd2, 16'h0);
      chk_ent("R1", 2, 1'b0, 5'h11, 5'd3, 16'h0);
      do_req(3'd0, A_P3R4, 0, 0, 0);
      chk("R2", "entries back p3", nent, 3);
      chk_ent("R2", 0, 1'b1, 5'h18, 5'd0, 16'h0003);
      chk("R2", "data", rd_d, 32'hDEAD55EF);
   endtask

   task automatic t_half;           // R9
      do_req(3'd7, A_P3R4, 32'hCAFE1111, 0, 0);
      chk("R9", "hi write entries", nent, 1);
      chk_ent("R9", 0, 1'b1, 5'h12, 5'd5, 16'hCAFE);
      do_req(3'd6, A_P3R8, 32'h2222ABCD, 0, 0);
      chk("R9", "lo write entries", nent, 1);
      chk_ent("R9", 0, 1'b1, 5'h12, 5'd8, 16'hABCD);
      do_req(3'd4, A_P3R4, 0, 0, 0);
      chk("R9", "lo read entries", nent, 1);
      chk_ent("R9", 0, 1'b0, 5'h12, 5'd4, 16'h0);
      chk("R9", "lo read data", rd_d, 32'h000055EF);
      do_req(3'd5, A_P3R4, 0, 0, 0);
      chk_ent("R9", 0, 1'b0, 5'h12, 5'd5, 16'h0);
      chk("R9", "hi read data", rd_d, 32'hCAFE0000);
   endtask

   task automatic t_poll_hit;       // R7
      cfg_lo_first = 1'b1;
      do_req(3'd1, A_P3R8, 32'h0, 0, 0);
      poll_val  = 16'h0001;
      poll_base = tgt_reads + 3;
      do_req(3'd3, A_P3R8, 32'h1, 32'h1, 16'd10);
      chk("R7", "reads", nent, 6);
      chk("R7", "err", {31'b0, rd_e}, 32'd0);
      chk("R7", "data", rd_d, 32'h00000001);
      chk_ent("R7", 4, 1'b0, 5'h12, 5'd8, 16'h0);
      chk("R7", "gap ok", {31'b0, (log_t[base+2] - log_t[base+1]) >= GAP}, 32'd1);
      poll_base = 32'h7FFF_FFFF;
   endtask

   task automatic t_poll_timeout;   // R8
      do_req(3'd3, A_P3R8, 32'h42, 32'hFF, 16'd2);
      chk("R8", "attempt reads", nent, 6);
      chk("R8", "err", {31'b0, rd_e}, 32'd1);
   endtask

   task automatic t_err;            // R10
      err_inj = 1'b1;
      do_req(3'd0, A_P3R4, 0, 0, 0);
      chk("R10", "err set", {31'b0, rd_e}, 32'd1);
      err_inj = 1'b0;
      do_req(3'd0, A_P3R4, 0, 0, 0);
      chk("R10", "err cleared", {31'b0, rd_e}, 32'd0);
      chk("R10", "data", rd_d, 32'hCAFE55EF);
   endtask

   logic finished = 1'b0;

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; cfg_lo_first = 1'b1;
      req_op = 3'd0; req_addr = '0; req_wdata = '0; req_mask = '0; req_timeout = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_read();
      t_write_lofirst();
      t_read_same_page();
      t_write_hifirst();
      t_rmw();
      t_page_switch();
      t_half();
      t_poll_hit();
      t_poll_timeout();
      t_err();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R11 watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule